// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block watches the stream of conversion results as they are written into result storage and checks the results of one chosen input channel against a programmable 12-bit threshold. It can test for a result below the threshold or for a result at or above it. The test is unsigned or two's complement, following the result format select. The block asks for the condition several times in a row before it reports. A programmable number of consecutive qualifying results (setting plus one) on the chosen channel must arrive before a sticky flag is raised. An interrupt request follows the flag when it is enabled.

Software clears the flag with a one-cycle clear pulse, the equivalent of writing 1 to it. To get two independent monitors, place two instances side by side on the same result stream. Result storage and conversion sequencing sit outside this block.

Top module: `adc_win_compare`

## Requirements
- R1: After reset, `flag_o` and `irq_o` are 0 and the match count is zero.
- R2: A result is examined only when `cfg_en` is 1, `load_stb` is 1 and `load_chan` equals `cfg_chan`. A load for any other channel leaves the match count unchanged, whatever its value.
- R3: With `cfg_cond_ge` = 0 a result matches when it is strictly less than `cfg_thresh`. With `cfg_cond_ge` = 1 it matches when it is greater than or equal to `cfg_thresh`, so an equal result matches only under `cfg_cond_ge` = 1.
- R4: Each matching examined result adds one to the match count. The examined result that brings the count to `cfg_match_cnt` + 1 sets `flag_o`, which is visible after the clock edge that samples that load.
- R5: An examined result that does not match returns the match count to zero.
- R6: While `cfg_en` is 0 the match count is held at zero and `flag_o` cannot be set.
- R7: `flag_o` stays 1 until a cycle with `flag_clr` = 1 clears it. A set and a clear in the same cycle leave `flag_o` at 1.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and `cfg_irq_en` is 1.
- R9: With `fmt_signed` = 0, results and threshold compare as unsigned 12-bit values. With `fmt_signed` = 1 both compare as 12-bit two's complement, where bit 11 is the sign.
- R10: Setting the flag also returns the match count to zero. A further `cfg_match_cnt` + 1 matches are needed before the next set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Compare enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_cond_ge | input | 1 | 0: less than, 1: greater or equal |
| cfg_chan | input | 3 | Monitored channel |
| cfg_match_cnt | input | 4 | Required consecutive matches minus one |
| cfg_thresh | input | 12 | Threshold, same format as results |
| fmt_signed | input | 1 | 0: unsigned, 1: two's complement |
| load_stb | input | 1 | A result is being loaded this cycle |
| load_chan | input | 3 | Channel of the loaded result |
| load_data | input | 12 | Loaded result |
| flag_clr | input | 1 | Clears the flag (write-one-to-clear) |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Compare interrupt request |

## Verification
The match count is internal, so an error in it shows up only when the flag rises too early or too late. The directed sequences therefore place misses, foreign-channel loads and enable gaps between matches, and then check the flag exactly one cycle after the load that should complete the run and one cycle after the load just before it. A wrong signed/unsigned choice shows up on the very next sample after a single load, because the stimulus uses values whose order differs between the two formats. A lost clear or a lost set shows up on the next sample.

// File: rtl/adc_wcmp_pkg.sv
package adc_wcmp_pkg;
   typedef enum logic {
      COND_BELOW       = 1'b0,
      COND_AT_OR_ABOVE = 1'b1
   } cmp_cond_e;

   localparam int unsigned DEF_DATA_W = 12;
   localparam int unsigned DEF_CHAN_W = 3;
   localparam int unsigned DEF_CNT_W  = 4;
endpackage

// File: rtl/adc_wcmp_compare.sv
module adc_wcmp_compare
   import adc_wcmp_pkg::*;
#(
   parameter int unsigned DATA_W     = DEF_DATA_W,
   parameter bit          BIAS_STYLE = 1'b1
) (
   input  logic [DATA_W-1:0] value_i,
   input  logic [DATA_W-1:0] thresh_i,
   input  logic              fmt_signed_i,
   input  cmp_cond_e         cond_i,
   output logic              hit_o
);
   localparam int unsigned MSB = DATA_W - 1;

   logic below;

   generate
      if (BIAS_STYLE) begin : g_bias
         logic [DATA_W-1:0] val_b, thr_b;
         always_comb begin
            val_b      = value_i;
            thr_b      = thresh_i;
            val_b[MSB] = value_i[MSB] ^ fmt_signed_i;
            thr_b[MSB] = thresh_i[MSB] ^ fmt_signed_i;
            below      = val_b < thr_b;
         end
      end else begin : g_mux
         always_comb begin
            if (fmt_signed_i) below = $signed(value_i) < $signed(thresh_i);
            else              below = value_i < thresh_i;
         end
      end
   endgenerate

   assign hit_o = (cond_i == COND_AT_OR_ABOVE) ? !below : below;
endmodule

// File: rtl/adc_wcmp_counter.sv
module adc_wcmp_counter #(
   parameter int unsigned CNT_W = adc_wcmp_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             qualify_i,
   input  logic             hit_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             set_o,
   output logic [CNT_W-1:0] count_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             reached;

   assign reached = cnt_q >= limit_i;
   assign set_o   = enable_i && qualify_i && hit_i && reached;
   assign count_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable_i) begin
         cnt_q <= '0;
      end else if (qualify_i) begin
         if (!hit_i)       cnt_q <= '0;
         else if (reached) cnt_q <= '0;
         else              cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/adc_wcmp_flag.sv
module adc_wcmp_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/adc_win_compare.sv
module adc_win_compare
   import adc_wcmp_pkg::*;
#(
   parameter int unsigned DATA_W     = DEF_DATA_W,
   parameter int unsigned CHAN_W     = DEF_CHAN_W,
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter bit          BIAS_STYLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_irq_en,
   input  logic              cfg_cond_ge,
   input  logic [CHAN_W-1:0] cfg_chan,
   input  logic [CNT_W-1:0]  cfg_match_cnt,
   input  logic [DATA_W-1:0] cfg_thresh,
   input  logic              fmt_signed,
   input  logic              load_stb,
   input  logic [CHAN_W-1:0] load_chan,
   input  logic [DATA_W-1:0] load_data,
   input  logic              flag_clr,
   output logic              flag_o,
   output logic              irq_o
);
   generate
      if (DATA_W < 2)  begin : g_bad_data  $error("DATA_W must be at least 2");  end
      if (CHAN_W < 1)  begin : g_bad_chan  $error("CHAN_W must be at least 1");  end
      if (CNT_W < 1)   begin : g_bad_cnt   $error("CNT_W must be at least 1");   end
   endgenerate

   logic             qualify;
   logic             hit;
   logic             set_pulse;
   logic [CNT_W-1:0] cnt_q;
   cmp_cond_e        cond;

   assign qualify = load_stb && (load_chan == cfg_chan);
   assign cond    = cfg_cond_ge ? COND_AT_OR_ABOVE : COND_BELOW;

   adc_wcmp_compare #(
      .DATA_W     (DATA_W),
      .BIAS_STYLE (BIAS_STYLE)
   ) cmp_i (
      .value_i      (load_data),
      .thresh_i     (cfg_thresh),
      .fmt_signed_i (fmt_signed),
      .cond_i       (cond),
      .hit_o        (hit)
   );

   adc_wcmp_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (cfg_en),
      .qualify_i (qualify),
      .hit_i     (hit),
      .limit_i   (cfg_match_cnt),
      .set_o     (set_pulse),
      .count_o   (cnt_q)
   );

   adc_wcmp_flag flg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_pulse),
      .clr_i    (flag_clr),
      .irq_en_i (cfg_irq_en),
      .flag_o   (flag_o),
      .irq_o    (irq_o)
   );
endmodule

// File: rtl/adc_wcmp_chk.sv
module adc_wcmp_chk #(
   parameter int unsigned CHAN_W = 3,
   parameter int unsigned CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic [CHAN_W-1:0] cfg_chan,
   input logic              load_stb,
   input logic [CHAN_W-1:0] load_chan,
   input logic              flag_clr,
   input logic              set_pulse,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              flag_o,
   input logic              irq_o
);
   // R2: without an examined load the count does not move
   p_hold_other_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !(load_stb && load_chan == cfg_chan)) |=> (cnt_q == $past(cnt_q)));

   // R4: the flag only rises after an examined load
   p_rise_needs_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(cfg_en && load_stb && load_chan == cfg_chan));

   // R6: disabled compare empties the count
   p_disabled_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (cnt_q == '0));

   // R7: the flag holds without a clear
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !flag_clr) |=> flag_o);

   // R7: a clear without a set empties the flag
   p_flag_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !set_pulse) |=> !flag_o);

   // R8: no interrupt without the flag
   p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);

   // R10: a set leaves the count empty
   p_restart_after_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> (cnt_q == '0));
endmodule

bind adc_win_compare adc_wcmp_chk #(
   .CHAN_W (CHAN_W),
   .CNT_W  (CNT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .cfg_chan  (cfg_chan),
   .load_stb  (load_stb),
   .load_chan (load_chan),
   .flag_clr  (flag_clr),
   .set_pulse (set_pulse),
   .cnt_q     (cnt_q),
   .flag_o    (flag_o),
   .irq_o     (irq_o)
);

// File: tb/adc_win_compare_tb_top.sv
`timescale 1ns/100ps
module adc_win_compare_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic        cfg_irq_en = 1'b0;
   logic        cfg_cond_ge = 1'b0;
   logic [2:0]  cfg_chan = '0;
   logic [3:0]  cfg_match_cnt = '0;
   logic [11:0] cfg_thresh = '0;
   logic        fmt_signed = 1'b0;
   logic        load_stb = 1'b0;
   logic [2:0]  load_chan = '0;
   logic [11:0] load_data = '0;
   logic        flag_clr = 1'b0;
   logic        flag_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   adc_win_compare dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
      .cfg_cond_ge(cfg_cond_ge), .cfg_chan(cfg_chan), .cfg_match_cnt(cfg_match_cnt),
      .cfg_thresh(cfg_thresh), .fmt_signed(fmt_signed), .load_stb(load_stb),
      .load_chan(load_chan), .load_data(load_data), .flag_clr(flag_clr),
      .flag_o(flag_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one load, drive at negedge, returns at next negedge (flag already updated)
   task automatic load(input logic [2:0] ch, input logic [11:0] d);
      load_stb = 1'b1; load_chan = ch; load_data = d;
      @(negedge clk);
      load_stb = 1'b0;
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic setup(input logic ge, input logic sgn, input logic [2:0] ch,
                        input logic [3:0] mc, input logic [11:0] th);
      cfg_en = 1'b1; cfg_cond_ge = ge; fmt_signed = sgn; cfg_chan = ch;
      cfg_match_cnt = mc; cfg_thresh = th;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 flag after reset", flag_o, 1'b0);
      check("R1 irq after reset", irq_o, 1'b0);
   endtask

   task automatic t_count_and_irq();
      setup(1'b0, 1'b0, 3'd2, 4'd2, 12'd100);
      load(3'd2, 12'd50);
      load(3'd2, 12'd50);
      check("R4 two of three", flag_o, 1'b0);
      load(3'd2, 12'd50);
      check("R4 third match sets", flag_o, 1'b1);
      check("R8 irq masked", irq_o, 1'b0);
      cfg_irq_en = 1'b1; #1;
      check("R8 irq enabled", irq_o, 1'b1);
      clear_flag();
      check("R7 cleared", flag_o, 1'b0);
      check("R8 irq follows clear", irq_o, 1'b0);
      cfg_irq_en = 1'b0;
   endtask

   task automatic t_miss_resets();
      setup(1'b0, 1'b0, 3'd2, 4'd2, 12'd100);
      load(3'd2, 12'd10);
      load(3'd2, 12'd10);
      load(3'd2, 12'd100);   // equal: no match under less-than
      load(3'd2, 12'd10);
      load(3'd2, 12'd10);
      check("R5 miss restarted run", flag_o, 1'b0);
      check("R3 equal is not below", flag_o, 1'b0);
      load(3'd2, 12'd10);
      check("R5 full run after miss", flag_o, 1'b1);
      clear_flag();
   endtask

   task automatic t_other_chan();
      setup(1'b0, 1'b0, 3'd2, 4'd1, 12'd100);
      load(3'd2, 12'd10);
      load(3'd5, 12'd900);   // would miss, must be ignored
      check("R2 foreign load ignored", flag_o, 1'b0);
      load(3'd2, 12'd10);
      check("R2 run kept across foreign load", flag_o, 1'b1);
      clear_flag();
      setup(1'b0, 1'b0, 3'd2, 4'd0, 12'd100);
      load(3'd3, 12'd0);
      check("R2 foreign match no flag", flag_o, 1'b0);
   endtask

   task automatic t_formats();
      setup(1'b1, 1'b1, 3'd4, 4'd0, 12'hF00);   // -256
      load(3'd4, 12'hE00);                       // -512
      check("R9 signed -512 not >= -256", flag_o, 1'b0);
      load(3'd4, 12'h001);
      check("R9 signed 1 >= -256", flag_o, 1'b1);
      clear_flag();
      setup(1'b1, 1'b0, 3'd4, 4'd0, 12'hF00);
      load(3'd4, 12'h001);
      check("R9 unsigned 1 not >= 0xF00", flag_o, 1'b0);
      load(3'd4, 12'hF00);
      check("R3 equal matches ge", flag_o, 1'b1);
      clear_flag();
      setup(1'b0, 1'b1, 3'd4, 4'd0, 12'h010);
      load(3'd4, 12'h800);
      check("R9 signed -2048 below 16", flag_o, 1'b1);
      clear_flag();
      setup(1'b0, 1'b0, 3'd4, 4'd0, 12'h010);
      load(3'd4, 12'h800);
      check("R9 unsigned 2048 not below 16", flag_o, 1'b0);
   endtask

   task automatic t_disable();
      setup(1'b0, 1'b0, 3'd1, 4'd1, 12'd100);
      load(3'd1, 12'd5);
      cfg_en = 1'b0;
      @(negedge clk);
      cfg_en = 1'b1;
      load(3'd1, 12'd5);
      check("R6 disable cleared run", flag_o, 1'b0);
      load(3'd1, 12'd5);
      check("R6 run after re-enable", flag_o, 1'b1);
      clear_flag();
      cfg_match_cnt = 4'd0; cfg_en = 1'b0;
      load(3'd1, 12'd5);
      check("R6 disabled no set", flag_o, 1'b0);
      cfg_en = 1'b1;
   endtask

   task automatic t_sticky_restart();
      setup(1'b0, 1'b0, 3'd6, 4'd0, 12'd100);
      load(3'd6, 12'd1);
      load(3'd6, 12'd500);
      load(3'd6, 12'd500);
      check("R7 flag holds over misses", flag_o, 1'b1);
      clear_flag();
      flag_clr = 1'b1;
      load(3'd6, 12'd1);
      flag_clr = 1'b0;
      check("R7 set wins over clear", flag_o, 1'b1);
      clear_flag();
      setup(1'b0, 1'b0, 3'd6, 4'd1, 12'd100);
      load(3'd6, 12'd1);
      load(3'd6, 12'd1);
      check("R10 first run sets", flag_o, 1'b1);
      clear_flag();
      load(3'd6, 12'd1);
      check("R10 count restarted", flag_o, 1'b0);
      load(3'd6, 12'd1);
      check("R10 second run sets", flag_o, 1'b1);
      clear_flag();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count_and_irq();
      t_miss_resets();
      t_other_chan();
      t_formats();
      t_disable();
      t_sticky_restart();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule